// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block tracks the coherence state of every line of one direct-mapped copy-back cache that sits on a shared bus. The local processor presents line-address requests (read or write) together with a page attribute that picks copy-back, write-through or private (unsnooped) handling. On a miss or an ownership upgrade the controller issues whole-line bus commands. It also watches transactions from other bus masters, which may be other caches or an I/O DMA engine without a cache, and answers each one with snoop response bits. Those transactions can force writebacks and invalidations.

Line states are Invalid, Shared, Exclusive and Modified. A plain read fills as Exclusive unless another agent reports sharing. A write first gains ownership with a read-with-intent-to-modify. Dirty data is written back as a full burst before any other agent may use it. The data array and the memory behind the bus live outside this block. It only steers them through its commands and its completion strobe.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: no bus command is pending, `lcl_ready` is high, and a snooped read of any address gets `snp_resp_valid` with `snp_shared` and `snp_dirty` low.
- R2: A local read miss issues bus command READ (code 1) at the line address. The command lasts `LINE_WORDS` beats (4 or 8). The line fills Exclusive when `bus_shared_in` is low on the last beat and Shared when it is high, and `lcl_done` pulses the cycle after that beat.
- R3: With copy-back attribute (code 0), a write that hits an Exclusive or Modified line completes the next cycle with no bus command, and the line becomes Modified. A write that hits a Shared line, or misses, first issues RWITM (code 2) for the line and then leaves it Modified.
- R4: A snooped cache read (kind 0) that hits a clean line raises `snp_shared` without `snp_dirty`, and the line becomes Shared.
- R5: A snooped cache read that hits a Modified line raises `snp_shared` and `snp_dirty`. It then issues a WB (code 3) burst of `LINE_WORDS` beats to that address, after which the line is Shared.
- R6: A snooped RWITM (kind 1) that hits a valid line raises `snp_inval` and leaves the line Invalid. When the line was Modified, a WB burst comes first.
- R7: An I/O write (kind 3) that hits invalidates the line without a writeback. An I/O read (kind 2) that hits a Modified line forces a WB burst and leaves the line Exclusive.
- R8: A write with write-through attribute (code 1) issues a single-beat WRITE (code 4) and never moves a line to Modified. A hit keeps its state, and a miss allocates nothing.
- R9: Lines filled under the private attribute (code 2) are not snooped. A snoop of them gives no shared, dirty or invalidate response and leaves their state unchanged.
- R10: The snoop response appears one clock after `snp_valid`. `lcl_ready` is low while `snp_valid` is high and while any bus command is outstanding, so a conflicting local request waits for the snoop to finish.
- R11: A miss whose line holds a Modified line of another tag first writes that victim back with WB at its own address. Only then is the fill command issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lcl_valid | input | 1 | Local request present |
| lcl_write | input | 1 | Local request is a write |
| lcl_attr | input | 2 | Page attribute: 0 copy-back, 1 write-through, 2 private |
| lcl_addr | input | AW | Local line address |
| lcl_ready | output | 1 | Local request accepted this cycle when valid |
| lcl_done | output | 1 | Local request completed |
| bus_cmd_valid | output | 1 | Bus command outstanding |
| bus_cmd | output | 3 | 1 READ, 2 RWITM, 3 WB, 4 WRITE |
| bus_addr | output | AW | Line address of the bus command |
| bus_beat | input | 1 | One data beat of the current command transferred |
| bus_shared_in | input | 1 | Other agents hold the line (sampled on last fill beat) |
| snp_valid | input | 1 | Foreign bus transaction to snoop |
| snp_kind | input | 2 | 0 cache read, 1 cache RWITM, 2 I/O read, 3 I/O write |
| snp_addr | input | AW | Line address of the foreign transaction |
| snp_resp_valid | output | 1 | Snoop response present |
| snp_shared | output | 1 | Snoop hit a valid line on a read |
| snp_dirty | output | 1 | Snoop hit a Modified line; writeback follows |
| snp_inval | output | 1 | Snoop invalidated a line |

## Verification
On every cycle the assertions check the snoop timing and the stall rule. They also check that a dirty response is always followed by a WB command, that an outstanding command holds still until its beats arrive, and that invalidations and completions never overlap an outstanding command in conflicting ways. Line states can only be seen through later behaviour, so the directed scenarios chain operations to read them out. An Exclusive line shows itself by a silent write, a Shared line by an RWITM upgrade, a Modified line by a dirty snoop and an Invalid line by a missing response. Those scenarios alone cover the fill state chosen by `bus_shared_in`, the private-page immunity, write-through never dirtying a line, and the victim writeback order.

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl #(
  parameter int AW = 16,
  parameter int NLINES = 8,
  parameter int LINE_WORDS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lcl_valid,
  input  logic          lcl_write,
  input  logic [1:0]    lcl_attr,
  input  logic [AW-1:0] lcl_addr,
  output logic          lcl_ready,
  output logic          lcl_done,
  output logic          bus_cmd_valid,
  output logic [2:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  input  logic          bus_beat,
  input  logic          bus_shared_in,
  input  logic          snp_valid,
  input  logic [1:0]    snp_kind,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_resp_valid,
  output logic          snp_shared,
  output logic          snp_dirty,
  output logic          snp_inval
);
  localparam int IW = $clog2(NLINES);
  localparam int TW = AW - IW;
  localparam int BW = $clog2(LINE_WORDS);
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [2:0] C_NONE = 3'd0, C_RD = 3'd1, C_RWITM = 3'd2, C_WB = 3'd3, C_WR = 3'd4;
  localparam logic [1:0] K_RD = 2'd0, K_RWITM = 2'd1, K_IORD = 2'd2, K_IOWR = 2'd3;
  localparam logic [1:0] A_WT = 2'd1, A_PRIV = 2'd2;

  typedef enum logic [1:0] {IDLE, LBUS, SWB} fsm_t;
  fsm_t st;

  logic [1:0]    ls [NLINES];
  logic [TW-1:0] tg [NLINES];
  logic          pv [NLINES];

  logic [AW-1:0] p_addr;
  logic          p_write;
  logic [1:0]    p_attr;
  logic [1:0]    s_kind;
  logic [IW-1:0] s_idx;
  logic [BW-1:0] cnt;

  wire [IW-1:0] li = lcl_addr[IW-1:0];
  wire [TW-1:0] lt = lcl_addr[AW-1:IW];
  wire          lhit = (ls[li] != ST_I) && (tg[li] == lt);
  wire [IW-1:0] si = snp_addr[IW-1:0];
  wire          shit = (ls[si] != ST_I) && (tg[si] == snp_addr[AW-1:IW]) && !pv[si];
  wire          s_wb = shit && (ls[si] == ST_M) && (snp_kind != K_IOWR);
  wire [IW-1:0] pi = p_addr[IW-1:0];
  wire          last = (bus_cmd == C_WR) || (cnt == BW'(LINE_WORDS - 1));

  assign lcl_ready     = (st == IDLE) && !snp_valid;
  assign bus_cmd_valid = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) begin
        ls[i] <= ST_I;
        tg[i] <= '0;
        pv[i] <= 1'b0;
      end
      st <= IDLE;
      bus_cmd <= C_NONE;
      bus_addr <= '0;
      p_addr <= '0;
      p_write <= 1'b0;
      p_attr <= '0;
      s_kind <= '0;
      s_idx <= '0;
      cnt <= '0;
      lcl_done <= 1'b0;
      snp_resp_valid <= 1'b0;
      snp_shared <= 1'b0;
      snp_dirty <= 1'b0;
      snp_inval <= 1'b0;
    end else begin
      lcl_done <= 1'b0;
      snp_resp_valid <= 1'b0;
      snp_shared <= 1'b0;
      snp_dirty <= 1'b0;
      snp_inval <= 1'b0;
      case (st)
        IDLE: begin
          if (snp_valid) begin
            snp_resp_valid <= 1'b1;
            if (shit) begin
              snp_shared <= (snp_kind == K_RD) || (snp_kind == K_IORD);
              snp_dirty  <= s_wb;
              snp_inval  <= (snp_kind == K_RWITM) || (snp_kind == K_IOWR);
              if (s_wb) begin
                st <= SWB;
                bus_cmd <= C_WB;
                bus_addr <= snp_addr;
                cnt <= '0;
                s_kind <= snp_kind;
                s_idx <= si;
              end else if (snp_kind == K_RD) begin
                ls[si] <= ST_S;
              end else if (snp_kind != K_IORD) begin
                ls[si] <= ST_I;
              end
            end
          end else if (lcl_valid) begin
            p_addr <= lcl_addr;
            p_write <= lcl_write;
            p_attr <= lcl_attr;
            cnt <= '0;
            if (lhit && !lcl_write) begin
              lcl_done <= 1'b1;
            end else if (lcl_write && lcl_attr == A_WT) begin
              st <= LBUS;
              bus_cmd <= C_WR;
              bus_addr <= lcl_addr;
            end else if (lhit && ls[li] != ST_S) begin
              ls[li] <= ST_M;
              lcl_done <= 1'b1;
            end else if (lhit) begin
              st <= LBUS;
              bus_cmd <= C_RWITM;
              bus_addr <= lcl_addr;
            end else if (ls[li] == ST_M) begin
              st <= LBUS;
              bus_cmd <= C_WB;
              bus_addr <= {tg[li], li};
            end else begin
              st <= LBUS;
              bus_cmd <= lcl_write ? C_RWITM : C_RD;
              bus_addr <= lcl_addr;
            end
          end
        end
        LBUS: begin
          if (bus_beat) begin
            cnt <= cnt + 1'b1;
            if (last) begin
              cnt <= '0;
              case (bus_cmd)
                C_WB: begin
                  ls[pi] <= ST_I;
                  bus_cmd <= p_write ? C_RWITM : C_RD;
                  bus_addr <= p_addr;
                end
                C_RD, C_RWITM: begin
                  ls[pi] <= (bus_cmd == C_RWITM) ? ST_M : (bus_shared_in ? ST_S : ST_E);
                  tg[pi] <= p_addr[AW-1:IW];
                  pv[pi] <= (p_attr == A_PRIV);
                  st <= IDLE;
                  bus_cmd <= C_NONE;
                  lcl_done <= 1'b1;
                end
                default: begin
                  st <= IDLE;
                  bus_cmd <= C_NONE;
                  lcl_done <= 1'b1;
                end
              endcase
            end
          end
        end
        default: begin
          if (bus_beat) begin
            cnt <= cnt + 1'b1;
            if (last) begin
              cnt <= '0;
              ls[s_idx] <= (s_kind == K_RD) ? ST_S : (s_kind == K_RWITM) ? ST_I : ST_E;
              st <= IDLE;
              bus_cmd <= C_NONE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lcl_ready,
  input logic          lcl_done,
  input logic          bus_cmd_valid,
  input logic [2:0]    bus_cmd,
  input logic [AW-1:0] bus_addr,
  input logic          bus_beat,
  input logic          snp_valid,
  input logic          snp_resp_valid,
  input logic          snp_shared,
  input logic          snp_dirty,
  input logic          snp_inval
);
  assert_resp_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !bus_cmd_valid) |=> snp_resp_valid);

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid || bus_cmd_valid) |-> !lcl_ready);

  assert_dirty_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    snp_dirty |-> (bus_cmd_valid && bus_cmd == 3'd3));

  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_valid && !bus_beat) |=> (bus_cmd_valid && $stable(bus_cmd) && $stable(bus_addr)));

  assert_inval_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_inval |-> (snp_resp_valid && !snp_shared));

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_done |-> !bus_cmd_valid);
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lcl_ready(lcl_ready), .lcl_done(lcl_done),
  .bus_cmd_valid(bus_cmd_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
  .bus_beat(bus_beat), .snp_valid(snp_valid), .snp_resp_valid(snp_resp_valid),
  .snp_shared(snp_shared), .snp_dirty(snp_dirty), .snp_inval(snp_inval)
);

// File: tb/mesi_snoop_ctrl_tb.sv
module mesi_snoop_ctrl_tb;
  localparam int AW = 16;
  localparam int LW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lcl_valid = 0, lcl_write = 0;
  logic [1:0] lcl_attr = 0;
  logic [AW-1:0] lcl_addr = 0;
  logic lcl_ready, lcl_done, bus_cmd_valid;
  logic [2:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic bus_beat = 0, bus_shared_in = 0;
  logic snp_valid = 0;
  logic [1:0] snp_kind = 0;
  logic [AW-1:0] snp_addr = 0;
  logic snp_resp_valid, snp_shared, snp_dirty, snp_inval;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mesi_snoop_ctrl #(.AW(AW), .NLINES(8), .LINE_WORDS(LW)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic local_op(input logic wr, input logic [1:0] attr, input logic [AW-1:0] a);
    lcl_valid = 1; lcl_write = wr; lcl_attr = attr; lcl_addr = a;
    @(negedge clk);
    lcl_valid = 0; lcl_write = 0;
  endtask

  task automatic serve(input string req, input int cmd, input logic [AW-1:0] a, input logic sh);
    int n;
    for (int w = 0; w < 20 && !bus_cmd_valid; w++) @(negedge clk);
    chk({req, " cmd"}, bus_cmd_valid ? int'(bus_cmd) : 0, cmd);
    chk({req, " addr"}, int'(bus_addr), int'(a));
    n = (cmd == 4) ? 1 : LW;
    bus_beat = 1; bus_shared_in = sh;
    repeat (n) @(posedge clk);
    @(negedge clk);
    bus_beat = 0; bus_shared_in = 0;
  endtask

  task automatic snoop(input string req, input logic [1:0] k, input logic [AW-1:0] a,
                       input logic esh, input logic edt, input logic einv);
    snp_valid = 1; snp_kind = k; snp_addr = a;
    @(negedge clk);
    snp_valid = 0;
    chk({req, " resp_valid"}, snp_resp_valid, 1);
    chk({req, " shared"}, snp_shared, esh);
    chk({req, " dirty"}, snp_dirty, edt);
    chk({req, " inval"}, snp_inval, einv);
    if (edt) serve({req, " wb"}, 3, a, 0);
  endtask

  task automatic expect_silent(input string req);
    chk({req, " done"}, lcl_done, 1);
    chk({req, " no bus"}, bus_cmd_valid, 0);
  endtask

  task automatic t_reset;
    chk("R1 ready", lcl_ready, 1);
    chk("R1 no cmd", bus_cmd_valid, 0);
    chk("R1 no resp", snp_resp_valid, 0);
    snoop("R1 snoop miss", 2'd0, 16'h0100, 0, 0, 0);
  endtask

  task automatic t_fill_exclusive;
    local_op(0, 0, 16'h0100);
    serve("R2 read miss", 1, 16'h0100, 0);
    chk("R2 done", lcl_done, 1);
    local_op(1, 0, 16'h0100);
    expect_silent("R3 write E silent");
    snoop("R5 snoop rd on M", 2'd0, 16'h0100, 1, 1, 0);
    local_op(1, 0, 16'h0100);
    serve("R5 line now S upgrade", 2, 16'h0100, 0);
    chk("R3 upgrade done", lcl_done, 1);
    snoop("R6 rwitm on M", 2'd1, 16'h0100, 0, 1, 1);
    snoop("R6 line invalid", 2'd0, 16'h0100, 0, 0, 0);
  endtask

  task automatic t_fill_shared;
    local_op(0, 0, 16'h0201);
    serve("R2 shared fill", 1, 16'h0201, 1);
    local_op(1, 0, 16'h0201);
    serve("R2 S needs rwitm", 2, 16'h0201, 0);
    chk("R2 done", lcl_done, 1);
  endtask

  task automatic t_snoop_clean;
    local_op(0, 0, 16'h0302);
    serve("R4 fill", 1, 16'h0302, 0);
    snoop("R4 snoop rd clean", 2'd0, 16'h0302, 1, 0, 0);
    local_op(1, 0, 16'h0302);
    serve("R4 now shared", 2, 16'h0302, 0);
    local_op(0, 0, 16'h0403);
    serve("R6 fill", 1, 16'h0403, 0);
    snoop("R6 rwitm clean", 2'd1, 16'h0403, 0, 0, 1);
    chk("R6 no wb", bus_cmd_valid, 0);
    snoop("R6 clean now invalid", 2'd0, 16'h0403, 0, 0, 0);
  endtask

  task automatic t_io;
    local_op(1, 0, 16'h0504);
    serve("R3 write miss rwitm", 2, 16'h0504, 0);
    snoop("R7 io write on M", 2'd3, 16'h0504, 0, 0, 1);
    chk("R7 no wb", bus_cmd_valid, 0);
    snoop("R7 invalid after io write", 2'd0, 16'h0504, 0, 0, 0);
    local_op(0, 0, 16'h0504);
    serve("R7 refill", 1, 16'h0504, 0);
    local_op(1, 0, 16'h0504);
    expect_silent("R7 to M");
    snoop("R7 io read on M", 2'd2, 16'h0504, 1, 1, 0);
    local_op(1, 0, 16'h0504);
    expect_silent("R7 line E after io read");
  endtask

  task automatic t_write_through;
    local_op(0, 0, 16'h0605);
    serve("R8 fill", 1, 16'h0605, 0);
    local_op(1, 1, 16'h0605);
    serve("R8 wt hit", 4, 16'h0605, 0);
    chk("R8 done", lcl_done, 1);
    snoop("R8 not modified", 2'd0, 16'h0605, 1, 0, 0);
    local_op(1, 1, 16'h0716);
    serve("R8 wt miss", 4, 16'h0716, 0);
    snoop("R8 no allocate", 2'd0, 16'h0716, 0, 0, 0);
  endtask

  task automatic t_private;
    local_op(0, 2, 16'h0807);
    serve("R9 fill", 1, 16'h0807, 0);
    snoop("R9 rd ignored", 2'd0, 16'h0807, 0, 0, 0);
    local_op(1, 2, 16'h0807);
    expect_silent("R9 still E");
    snoop("R9 rwitm ignored", 2'd1, 16'h0807, 0, 0, 0);
    local_op(0, 2, 16'h0807);
    expect_silent("R9 still valid");
  endtask

  task automatic t_victim;
    local_op(0, 0, 16'h0A01);
    serve("R11 victim wb", 3, 16'h0201, 0);
    serve("R11 then fill", 1, 16'h0A01, 0);
    chk("R11 done", lcl_done, 1);
  endtask

  task automatic t_stall;
    lcl_valid = 1; lcl_write = 0; lcl_attr = 0; lcl_addr = 16'h0A01;
    snp_valid = 1; snp_kind = 2'd0; snp_addr = 16'h0807;
    #1;
    chk("R10 stall during snoop", lcl_ready, 0);
    @(negedge clk);
    snp_valid = 0;
    chk("R10 resp one clock later", snp_resp_valid, 1);
    chk("R10 local not done while stalled", lcl_done, 0);
    @(negedge clk);
    lcl_valid = 0;
    chk("R10 local served after snoop", lcl_done, 1);
    local_op(1, 0, 16'h0A01);
    expect_silent("R10 make M");
    lcl_valid = 1; lcl_write = 0; lcl_addr = 16'h0A01;
    snp_valid = 1; snp_kind = 2'd0; snp_addr = 16'h0A01;
    @(negedge clk);
    snp_valid = 0;
    chk("R10 dirty", snp_dirty, 1);
    chk("R10 stall during wb", lcl_ready, 0);
    serve("R10 wb", 3, 16'h0A01, 0);
    @(negedge clk);
    lcl_valid = 0;
    chk("R10 local after wb", lcl_done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill_exclusive();
    t_fill_shared();
    t_snoop_clean();
    t_io();
    t_write_through();
    t_private();
    t_victim();
    t_stall();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule